// File: doc/BRIEF.md
# DMA Slave Handshake Engine

This block moves a programmed number of bytes between an external DMA controller and an internal byte-wide buffer RAM. Transfers use an active-low request/acknowledge pair and share the processor's 8-bit bus and its read and write strobes. The processor loads a start address, a byte count and a direction through a small configuration port. It then sets the enable bit. The engine pulls its request line low and moves one byte for each strobe that completes while the acknowledge line is held low. When the remaining count reaches zero it releases the request and raises a completion flag, which serves as the interrupt output.

The engine runs only in peripheral mode. While the host-mode input is high, an enable is refused, and a block already in progress is stopped. Clearing the enable bit also stops a block early. The remaining count is left intact and stays visible on its output.

Top module: `dma_slave_engine`

## Requirements
- R1: After reset `drq_n` is 1, `done_irq` is 0, `dma_oe` is 0 and `left_cnt` is 0.
- R2: Configuration selects: `cfg_sel` 0 loads the start address, 1 loads the byte count, and 2 writes the control byte (bit 0 enable, bit 1 direction: 1 moves bytes into RAM, 0 moves bytes out of RAM). With host mode off and a nonzero count, a control write with bit 0 set drives `drq_n` to 0 on the following cycle.
- R3: In the into-RAM direction, each rising edge of `wr_n` with `dack_n` low stores `dma_din` at the address pointer. The pointer then advances by one.
- R4: In the out-of-RAM direction, while `dack_n` and `rd_n` are both low, `dma_oe` is 1 and `dma_dout` carries the byte at the pointer. Each rising edge of `rd_n` advances the pointer by one.
- R5: `left_cnt` drops by one for each byte moved. When the last byte is moved, `drq_n` returns to 1 and `done_irq` becomes 1.
- R6: An enable with a programmed count of zero sets `done_irq` on the next cycle and leaves `drq_n` at 1.
- R7: While `host_mode` is 1, an enable is ignored (`drq_n` stays 1 and `done_irq` stays 0). Raising `host_mode` during a block releases `drq_n` on the next cycle.
- R8: A control write with bit 0 clear stops a block. `drq_n` goes to 1, `left_cnt` keeps its value, and later strobes move no byte.
- R9: A strobe edge that occurs while `dack_n` is high moves no byte and leaves `left_cnt` unchanged.
- R10: Any control write clears `done_irq`.
- R11: The address pointer wraps from the last RAM location to address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host mode, which disables the engine |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| dack_n | input | 1 | Active-low DMA acknowledge |
| wr_n | input | 1 | Active-low write strobe on the shared bus |
| rd_n | input | 1 | Active-low read strobe on the shared bus |
| dma_din | input | 8 | Byte driven by the DMA controller |
| dma_dout | output | 8 | Byte returned to the DMA controller |
| dma_oe | output | 1 | Bus drive enable for `dma_dout` |
| drq_n | output | 1 | Active-low DMA request |
| left_cnt | output | 8 | Bytes still to move |
| done_irq | output | 1 | Block completion flag (interrupt) |

## Verification
Blocks of 1, 2, 3 and 5 bytes are written and then read back from a low start address, a mid-RAM start address and a start address three bytes from the top. This separates errors in count handling from errors in pointer stepping and wrap-around. Each byte carries a value derived from its address and the block index, so a stale or misplaced byte from an earlier block is detected. Separate sequences cover a zero count, host mode both before and during a block, a stop in mid-block followed by further strobes, and strobes sent without acknowledge. Each of these separates a refused transfer from a silently accepted one.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_CNT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic wr_n;
    logic rd_n;
    logic dack_n;
  } strobe_t;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_DIR_BIT = 1;

endpackage

// File: rtl/dma_strobe_sync.sv
module dma_strobe_sync #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              dack_n,
  input  logic [DATA_W-1:0] din,
  output logic              wr_rise,
  output logic              rd_rise,
  output logic              ack_held,
  output logic              rd_active,
  output logic [DATA_W-1:0] data_q
);
  import dma_eng_pkg::*;

  strobe_t           s1, s2;
  logic [DATA_W-1:0] d1, d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '1;
      s2 <= '1;
      d1 <= '0;
      d2 <= '0;
    end else begin
      s1 <= '{wr_n: wr_n, rd_n: rd_n, dack_n: dack_n};
      s2 <= s1;
      d1 <= din;
      d2 <= d1;
    end
  end

  assign wr_rise   = s1.wr_n & ~s2.wr_n;
  assign rd_rise   = s1.rd_n & ~s2.rd_n;
  assign ack_held  = ~s2.dack_n;
  assign rd_active = ~s1.rd_n & ~s1.dack_n;
  assign data_q    = d2;

endmodule

// File: rtl/dma_buf_ram.sv
module dma_buf_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/dma_seq.sv
module dma_seq #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              wr_rise,
  input  logic              rd_rise,
  input  logic              ack_held,
  output logic              busy,
  output logic              dir_in,
  output logic              xfer,
  output logic [ADDR_W-1:0] ptr,
  output logic [CNT_W-1:0]  left,
  output logic              done
);
  import dma_eng_pkg::*;

  logic [ADDR_W-1:0] start_q;
  logic [CNT_W-1:0]  count_q;
  logic              en_req;

  assign xfer   = busy & ack_held & (dir_in ? wr_rise : rd_rise);
  assign en_req = cfg_we && (cfg_sel_e'(cfg_sel) == SEL_CTRL) && cfg_wdata[CTRL_EN_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      count_q <= '0;
      busy    <= 1'b0;
      dir_in  <= 1'b0;
      ptr     <= '0;
      left    <= '0;
      done    <= 1'b0;
    end else begin
      if (cfg_we) begin
        case (cfg_sel_e'(cfg_sel))
          SEL_ADDR: start_q <= cfg_wdata[ADDR_W-1:0];
          SEL_CNT:  count_q <= cfg_wdata[CNT_W-1:0];
          SEL_CTRL: begin
            done   <= 1'b0;
            dir_in <= cfg_wdata[CTRL_DIR_BIT];
            if (cfg_wdata[CTRL_EN_BIT] && !host_mode) begin
              if (count_q == '0) begin
                done <= 1'b1;
                busy <= 1'b0;
              end else begin
                busy <= 1'b1;
                ptr  <= start_q;
                left <= count_q;
              end
            end else begin
              busy <= 1'b0;
            end
          end
          default: ;
        endcase
      end else if (xfer) begin
        ptr  <= ptr + ADDR_W'(1);
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (host_mode) busy <= 1'b0;
    end
  end

  // R5
  busy_live_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (left != '0));

  // R7
  host_stop_chk: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> !busy);

  // R5
  last_byte_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !cfg_we && left == CNT_W'(1)) |=> (!busy && done));

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (xfer && !cfg_we) |=> (ptr == $past(ptr) + ADDR_W'(1)));

  // R6
  zero_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (en_req && !host_mode && count_q == '0) |=> (done && !busy));

endmodule

// File: rtl/dma_slave_engine.sv
module dma_slave_engine #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_mode,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              dack_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [DATA_W-1:0] dma_din,
  output logic [DATA_W-1:0] dma_dout,
  output logic              dma_oe,
  output logic              drq_n,
  output logic [CNT_W-1:0]  left_cnt,
  output logic              done_irq
);

  logic              wr_rise, rd_rise, ack_held, rd_active;
  logic [DATA_W-1:0] data_q;
  logic              busy, dir_in, xfer, done;
  logic [ADDR_W-1:0] ptr;
  logic [CNT_W-1:0]  left;
  logic              oe_q;

  dma_strobe_sync #(.DATA_W(DATA_W)) sync_i (
    .clk(clk), .rst(rst), .wr_n(wr_n), .rd_n(rd_n), .dack_n(dack_n),
    .din(dma_din), .wr_rise(wr_rise), .rd_rise(rd_rise),
    .ack_held(ack_held), .rd_active(rd_active), .data_q(data_q)
  );

  dma_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) seq_i (
    .clk(clk), .rst(rst), .host_mode(host_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .wr_rise(wr_rise),
    .rd_rise(rd_rise), .ack_held(ack_held), .busy(busy), .dir_in(dir_in),
    .xfer(xfer), .ptr(ptr), .left(left), .done(done)
  );

  dma_buf_ram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ram_i (
    .clk(clk), .we(xfer & dir_in), .waddr(ptr), .wdata(data_q),
    .raddr(ptr), .rdata(dma_dout)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= busy & ~dir_in & rd_active;
  end

  assign dma_oe   = oe_q;
  assign drq_n    = ~busy;
  assign left_cnt = left;
  assign done_irq = done;

  // R4
  oe_dir_chk: assert property (@(posedge clk) disable iff (rst)
    dma_oe |-> ($past(busy) && !$past(dir_in)));

endmodule

// File: tb/dma_slave_engine_tb.sv
module dma_slave_engine_tb_top;
  localparam int DEPTH = 256;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_mode = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [7:0] cfg_wdata = 8'd0;
  logic       dack_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1;
  logic [7:0] dma_din = 8'd0;
  logic [7:0] dma_dout;
  logic       dma_oe, drq_n, done_irq;
  logic [7:0] left_cnt;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  dma_slave_engine dut_i (
    .clk(clk), .rst(rst), .host_mode(host_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .dack_n(dack_n), .wr_n(wr_n),
    .rd_n(rd_n), .dma_din(dma_din), .dma_dout(dma_dout), .dma_oe(dma_oe),
    .drq_n(drq_n), .left_cnt(left_cnt), .done_irq(done_irq)
  );

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'(a * 7 + seed * 29 + 3);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input logic ack);
    @(negedge clk);
    dack_n = ~ack; wr_n = 1'b0; dma_din = d;
    repeat (2) @(negedge clk);
    wr_n = 1'b1;
    repeat (3) @(negedge clk);
    dack_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic get(output logic [7:0] d, output logic oe);
    @(negedge clk);
    dack_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    d = dma_dout; oe = dma_oe;
    rd_n = 1'b1;
    repeat (3) @(negedge clk);
    dack_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int starts [3] = '{0, 55, DEPTH - 3};
    int counts [4] = '{1, 2, 3, 5};
    int seed = 0;
    logic [7:0] rb;
    logic oe;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 drq_n", drq_n, 1);
    chk("R1 done_irq", done_irq, 0);
    chk("R1 dma_oe", dma_oe, 0);
    chk("R1 left_cnt", left_cnt, 0);

    foreach (starts[si]) begin
      foreach (counts[ci]) begin
        seed++;
        cfg(2'd0, 8'(starts[si]));
        cfg(2'd1, 8'(counts[ci]));
        cfg(2'd2, 8'h03);
        chk("R2 drq_n low after enable", drq_n, 0);
        chk("R10 done cleared by control write", done_irq, 0);
        for (int i = 0; i < counts[ci]; i++) begin
          put(pat((starts[si] + i) % DEPTH, seed), 1'b1);
          chk("R5 left_cnt step", left_cnt, counts[ci] - i - 1);
        end
        chk("R5 drq_n released", drq_n, 1);
        chk("R5 done set", done_irq, 1);
        cfg(2'd2, 8'h01);
        chk("R2 drq_n low for read", drq_n, 0);
        for (int i = 0; i < counts[ci]; i++) begin
          get(rb, oe);
          chk("R4 dma_oe during read", oe, 1);
          chk("R3 R4 R11 read-back byte", rb, pat((starts[si] + i) % DEPTH, seed));
        end
        chk("R5 read block done", done_irq, 1);
        chk("R4 dma_oe idle", dma_oe, 0);
      end
    end

    // R11 the last block wrapped; bytes at 0 and 1 come from it
    cfg(2'd0, 8'd0);
    cfg(2'd1, 8'd2);
    cfg(2'd2, 8'h01);
    for (int i = 0; i < 2; i++) begin
      get(rb, oe);
      chk("R11 wrapped byte", rb, pat(i, seed));
    end

    // R6 zero count
    cfg(2'd1, 8'd0);
    cfg(2'd2, 8'h03);
    chk("R6 done immediate", done_irq, 1);
    chk("R6 drq_n stays high", drq_n, 1);
    // R10 clear
    cfg(2'd2, 8'h00);
    chk("R10 done cleared", done_irq, 0);

    // R7 host mode refuses enable
    host_mode = 1'b1;
    cfg(2'd1, 8'd4);
    cfg(2'd2, 8'h03);
    chk("R7 drq_n in host mode", drq_n, 1);
    chk("R7 no done in host mode", done_irq, 0);
    host_mode = 1'b0;
    cfg(2'd2, 8'h03);
    chk("R7 enable in peripheral mode", drq_n, 0);
    put(8'h11, 1'b1);
    chk("R7 one byte moved", left_cnt, 3);
    @(negedge clk);
    host_mode = 1'b1;
    @(negedge clk);
    chk("R7 drq_n released by host mode", drq_n, 1);
    put(8'h22, 1'b1);
    chk("R7 no move in host mode", left_cnt, 3);
    host_mode = 1'b0;

    // R8 stop mid-block
    cfg(2'd1, 8'd5);
    cfg(2'd2, 8'h03);
    put(8'h33, 1'b1);
    put(8'h44, 1'b1);
    cfg(2'd2, 8'h02);
    chk("R8 drq_n after stop", drq_n, 1);
    chk("R8 left kept", left_cnt, 3);
    put(8'h55, 1'b1);
    chk("R8 strobe after stop ignored", left_cnt, 3);

    // R9 strobe without acknowledge
    cfg(2'd1, 8'd4);
    cfg(2'd2, 8'h03);
    put(8'h66, 1'b0);
    chk("R9 no move without ack", left_cnt, 4);
    chk("R9 drq_n still low", drq_n, 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule